// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This block gives an embedded processor core three timing services that share one free-running 64-bit time-base count: a down-counting interval timer that can reload itself, a fixed-interval timer that fires whenever a chosen time-base bit rises, and a watchdog. The watchdog moves through three stages. The first expiry arms it, the second raises an interrupt, and the third requests a reset of a software-chosen kind. Software configures the unit through a control register. It observes and acknowledges events through a status register whose flags are cleared by writing ones. It loads and reads the interval counter through a third register address.

The time base itself is outside the block. The unit samples its count every clock cycle and watches selected bits for 0-to-1 transitions. A separate step strobe marks each time-base advance and paces the interval counter. Generating the actual core, chip or system reset is left to the surrounding logic, which decodes the 2-bit reset request code.

Top module: `emb_timer_unit`

## Requirements
- R1: After a synchronous reset, the control register, status register, interval counter, all three interrupt outputs and `rst_req` read 0.
- R2: A write to register address 0 (control) stores only bits 31:22; bits 21:0 always read back as 0. Control fields: 31:30 watchdog period code, 29:28 watchdog reset kind, 27 watchdog interrupt enable, 26 interval interrupt enable, 25:24 fixed-interval period code, 23 fixed-interval interrupt enable, 22 interval auto-reload.
- R3: A write to address 1 (status) clears each of bits 31:26 written as 1 and leaves bits written as 0 unchanged. Status bits 25:0 always read as 0.
- R4: The fixed-interval period code 0..3 selects time-base bit 9, 13, 17 or 21. A 0-to-1 transition of the selected bit sets status bit 26. If control bit 23 is set, the same transition also raises `fit_irq`. Transitions of unselected bits have no effect. Writing 1 to status bit 26 drops `fit_irq`.
- R5: A write to address 2 loads the interval counter and its reload value. A read of address 2 returns the current count. Each cycle with `tb_step` high decrements the count by one.
- R6: When a step arrives with the count at 1, status bit 27 is set, and `pit_irq` is raised if control bit 26 is set. The count then takes the reload value if control bit 22 is set; otherwise it becomes 0 and counting stops.
- R7: With a reload value of 0 or 1, the counter never decrements and never expires.
- R8: The watchdog period code 0..3 selects time-base bit 17, 21, 25 or 29, and an event is a 0-to-1 transition of that bit. On an event with status bits 31 and 30 both clear, bit 31 is set.
- R9: On a watchdog event with bit 31 set and bit 30 clear, bit 30 is set, and `wdt_irq` is raised if control bit 27 is set.
- R10: On a watchdog event with status bit 30 set, control bits 29:28 are copied into status bits 29:28 and driven on `rst_req` for exactly one cycle (0 none, 1 core, 2 chip, 3 system).
- R11: Writing status bit 31 as 1 drops `pit_irq`. Clearing status bit 27 alone leaves `pit_irq` asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_count | input | 64 | Shared time-base count |
| tb_step | input | 1 | One time-base advance; paces the interval counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status, 2 interval counter |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same encoding |
| rd_data | output | 32 | Combinational read data |
| pit_irq | output | 1 | Interval timer interrupt request |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| wdt_irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 2 | One-cycle reset request code |

## Verification
A corrupted watchdog stage shows up on the first time-base edge that follows it. A stray set of bit 30 turns the next event into a reset request, which appears on `rst_req` one cycle after the edge. A lost set of bit 31 means `wdt_irq` never rises. A wrong interval count is visible through the address-2 read as soon as the next step occurs. An expiry that fires one step early or late shifts status bit 27 and `pit_irq` by exactly one step. Edge detection that triggers on level instead of transition would set status flags again right after software clears them, so the bench clears the flags and then reads status back while the tap bit stays high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_PIT  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [1:0]  wd_period;
        logic [1:0]  wd_rst_kind;
        logic        wd_irq_en;
        logic        pit_irq_en;
        logic [1:0]  fit_period;
        logic        fit_irq_en;
        logic        pit_autoload;
        logic [21:0] rsvd;
    } ctrl_t;

    typedef struct packed {
        logic        wd_armed;
        logic        wd_flag;
        logic [1:0]  wd_rst_seen;
        logic        pit_flag;
        logic        fit_flag;
        logic [25:0] rsvd;
    } stat_t;

    localparam logic [REG_W-1:0] CTRL_KEEP = 32'hFFC0_0000;
    localparam logic [REG_W-1:0] STAT_W1C  = 32'hFC00_0000;

    function automatic logic [REG_W-1:0] w1c_mask(input logic sel, input logic [REG_W-1:0] d);
        return sel ? (d & STAT_W1C) : '0;
    endfunction

endpackage

// File: rtl/tmr_tap_edge.sv
module tmr_tap_edge #(
    parameter int TB_W = 64,
    parameter int BASE = 9,
    parameter int STEP = 4,
    parameter int NSEL = 4,
    localparam int SW  = $clog2(NSEL)
) (
    input  logic            clk,
    input  logic [TB_W-1:0] tb,
    input  logic [SW-1:0]   sel,
    output logic            evt
);
    logic [NSEL-1:0] taps;
    logic [NSEL-1:0] prev;

    for (genvar g = 0; g < NSEL; g++) begin : g_tap
        assign taps[g] = tb[BASE + g*STEP];
    end

    // Previous value tracks every tap so a period change never fakes an edge.
    always_ff @(posedge clk) begin
        prev <= taps;
    end

    assign evt = taps[sel] & ~prev[sel];
endmodule

// File: rtl/tmr_pit_counter.sv
module tmr_pit_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         auto_reload,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         expire
);
    logic run;

    assign run    = (reload > W'(1)) && (count != '0);
    assign expire = step && run && (count == W'(1)) && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
        end else if (load) begin
            count  <= load_val;
            reload <= load_val;
        end else if (step && run) begin
            if (count == W'(1)) count <= auto_reload ? reload : '0;
            else                count <= count - W'(1);
        end
    end
endmodule

// File: rtl/emb_timer_unit.sv
module emb_timer_unit
    import tmr_pkg::*;
#(
    parameter int TB_W     = 64,
    parameter int FIT_BASE = 9,
    parameter int WD_BASE  = 17,
    parameter int TAP_STEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TB_W-1:0]  tb_count,
    input  logic             tb_step,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             pit_irq,
    output logic             fit_irq,
    output logic             wdt_irq,
    output logic [1:0]       rst_req
);
    ctrl_t            ctrl_q;
    stat_t            stat_q;
    logic [REG_W-1:0] stat_next;
    logic [REG_W-1:0] clr;
    logic             wr_ctrl, wr_stat, wr_pit;
    logic             fit_evt, wd_evt;
    logic             wd_arm, wd_bark, wd_fire;
    logic [REG_W-1:0] pit_count, pit_reload;
    logic             pit_expire;

    assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    assign wr_stat = wr_en && (wr_addr == REG_STAT);
    assign wr_pit  = wr_en && (wr_addr == REG_PIT);
    assign clr     = w1c_mask(wr_stat, wr_data);

    tmr_tap_edge #(.TB_W(TB_W), .BASE(FIT_BASE), .STEP(TAP_STEP), .NSEL(4)) u_fit_tap (
        .clk(clk), .tb(tb_count), .sel(ctrl_q.fit_period), .evt(fit_evt)
    );

    tmr_tap_edge #(.TB_W(TB_W), .BASE(WD_BASE), .STEP(TAP_STEP), .NSEL(4)) u_wd_tap (
        .clk(clk), .tb(tb_count), .sel(ctrl_q.wd_period), .evt(wd_evt)
    );

    tmr_pit_counter #(.W(REG_W)) u_pit (
        .clk(clk), .rst(rst), .load(wr_pit), .load_val(wr_data),
        .step(tb_step), .auto_reload(ctrl_q.pit_autoload),
        .count(pit_count), .reload(pit_reload), .expire(pit_expire)
    );

    // Watchdog stage decode from the two status flags
    assign wd_fire = wd_evt &&  stat_q.wd_flag;
    assign wd_bark = wd_evt && !stat_q.wd_flag &&  stat_q.wd_armed;
    assign wd_arm  = wd_evt && !stat_q.wd_flag && !stat_q.wd_armed;

    always_comb begin
        stat_next     = stat_q & ~clr;
        stat_next[31] = stat_next[31] | wd_arm;
        stat_next[30] = stat_next[30] | wd_bark;
        stat_next[27] = stat_next[27] | pit_expire;
        stat_next[26] = stat_next[26] | fit_evt;
        if (wd_fire) stat_next[29:28] = ctrl_q.wd_rst_kind;
        stat_next[25:0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            stat_q  <= '0;
            pit_irq <= 1'b0;
            fit_irq <= 1'b0;
            wdt_irq <= 1'b0;
            rst_req <= 2'b00;
        end else begin
            if (wr_ctrl) ctrl_q <= wr_data & CTRL_KEEP;
            stat_q <= stat_next;

            if (pit_expire && ctrl_q.pit_irq_en) pit_irq <= 1'b1;
            else if (clr[31])                    pit_irq <= 1'b0;

            if (fit_evt && ctrl_q.fit_irq_en)    fit_irq <= 1'b1;
            else if (clr[26])                    fit_irq <= 1'b0;

            if (wd_bark && ctrl_q.wd_irq_en)     wdt_irq <= 1'b1;
            else if (clr[30])                    wdt_irq <= 1'b0;

            rst_req <= wd_fire ? ctrl_q.wd_rst_kind : 2'b00;
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_CTRL: rd_data = ctrl_q;
            REG_STAT: rd_data = stat_q;
            REG_PIT:  rd_data = pit_count;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] ctrl_q,
    input logic [31:0] stat_q,
    input logic [31:0] pit_count,
    input logic [31:0] pit_reload,
    input logic        pit_expire,
    input logic        fit_evt,
    input logic        wr_pit,
    input logic        pit_irq,
    input logic        fit_irq,
    input logic        wdt_irq,
    input logic [1:0]  rst_req
);
    AST_PIT_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(pit_irq) |-> $past(pit_expire) && $past(ctrl_q[26])); // R6

    AST_FIT_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(fit_irq) |-> $past(fit_evt) && $past(ctrl_q[23])); // R4

    AST_WDT_IRQ_STAGE: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_irq) |-> $past(stat_q[31]) && !$past(stat_q[30])); // R9

    AST_RST_AFTER_BARK: assert property (@(posedge clk) disable iff (rst)
        (rst_req != 2'b00) |-> $past(stat_q[30])); // R10

    AST_PIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!wr_pit && pit_reload <= 32'd1) |=> $stable(pit_count)); // R7
endmodule

bind emb_timer_unit tmr_unit_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .pit_count(pit_count), .pit_reload(pit_reload), .pit_expire(pit_expire),
    .fit_evt(fit_evt), .wr_pit(wr_pit), .pit_irq(pit_irq), .fit_irq(fit_irq),
    .wdt_irq(wdt_irq), .rst_req(rst_req)
);

// File: tb/tb_emb_timer_unit.sv
module tb_emb_timer_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] tb_count = '0;
    logic        tb_step = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pit_irq, fit_irq, wdt_irq;
    logic [1:0]  rst_req;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    emb_timer_unit dut (
        .clk(clk), .rst(rst), .tb_count(tb_count), .tb_step(tb_step),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pit_irq(pit_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic set_tb(input logic [63:0] v);
        @(negedge clk); tb_count = v;
        @(negedge clk);
    endtask

    task automatic step(input int n);
        @(negedge clk); tb_step = 1'b1;
        repeat (n) @(negedge clk);
        tb_step = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 status", v, 0);
        rd(2'd2, v); chk("R1 pit", v, 0);
        chk("R1 irqs", {pit_irq, fit_irq, wdt_irq}, 0);
        chk("R1 rst_req", rst_req, 0);
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R2 mask", v, 32'hFFC0_0000);
        wr(2'd0, 32'h0000_0000); rd(2'd0, v); chk("R2 zero", v, 0);
    endtask

    task automatic t_fit;
        logic [31:0] v;
        set_tb(64'h200);            // bit 9 rises, period code 0
        rd(2'd1, v); chk("R4 tap9 flag", v, 32'h0400_0000);
        chk("R4 irq disabled", fit_irq, 0);
        wr(2'd1, 32'h0400_0000); rd(2'd1, v); chk("R3 w1c", v, 0);
        rd(2'd1, v); chk("R4 level no refire", v, 0);
        wr(2'd0, 32'h0180_0000);    // period code 1, irq enabled
        set_tb(64'h0); set_tb(64'h200);
        rd(2'd1, v); chk("R4 unselected tap", v, 0);
        set_tb(64'h2200);           // bit 13 rises
        rd(2'd1, v); chk("R4 tap13 flag", v, 32'h0400_0000);
        chk("R4 irq", fit_irq, 1);
        wr(2'd1, 32'h0000_0000); rd(2'd1, v); chk("R3 zero write", v, 32'h0400_0000);
        chk("R3 irq kept", fit_irq, 1);
        wr(2'd1, 32'h03FF_FFFF); rd(2'd1, v); chk("R3 low bits", v, 32'h0400_0000);
        wr(2'd1, 32'h0400_0000); chk("R4 irq clear", fit_irq, 0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_pit;
        logic [31:0] v;
        wr(2'd2, 32'd10); rd(2'd2, v); chk("R5 load", v, 10);
        step(3); rd(2'd2, v); chk("R5 decrement", v, 7);
        wr(2'd0, 32'h0400_0000);
        wr(2'd2, 32'd3); step(3);
        rd(2'd2, v); chk("R6 stopped at 0", v, 0);
        rd(2'd1, v); chk("R6 flag", v, 32'h0800_0000);
        chk("R6 irq", pit_irq, 1);
        step(2); rd(2'd2, v); chk("R6 no restart", v, 0);
        wr(2'd1, 32'h0800_0000); chk("R11 flag clear keeps irq", pit_irq, 1);
        wr(2'd1, 32'h8000_0000); chk("R11 bit31 drops irq", pit_irq, 0);
        wr(2'd0, 32'h0440_0000);
        wr(2'd2, 32'd4); step(4);
        rd(2'd2, v); chk("R6 autoreload", v, 4);
        rd(2'd1, v); chk("R6 autoreload flag", v, 32'h0800_0000);
        step(1); rd(2'd2, v); chk("R6 continues", v, 3);
        wr(2'd1, 32'hFC00_0000);
        wr(2'd2, 32'd1); step(5);
        rd(2'd2, v); chk("R7 reload 1 holds", v, 1);
        rd(2'd1, v); chk("R7 no expiry", v, 0);
        chk("R7 no irq", pit_irq, 0);
        wr(2'd2, 32'd0); step(2); rd(2'd2, v); chk("R7 reload 0 holds", v, 0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_wdog;
        logic [31:0] v;
        set_tb(64'h0);
        wr(2'd1, 32'hFC00_0000);
        wr(2'd0, 32'h6800_0000);    // period code 1 (bit 21), kind 2, irq on
        set_tb(64'h2_0000);
        rd(2'd1, v); chk("R8 unselected tap", v, 0);
        set_tb(64'h0);
        wr(2'd0, 32'h2800_0000);    // period code 0 (bit 17)
        set_tb(64'h2_0000);
        rd(2'd1, v); chk("R8 arm", v, 32'h8000_0000);
        chk("R8 no irq", wdt_irq, 0);
        set_tb(64'h0); set_tb(64'h2_0000);
        rd(2'd1, v); chk("R9 bark", v, 32'hC000_0000);
        chk("R9 irq", wdt_irq, 1);
        chk("R9 no reset yet", rst_req, 0);
        set_tb(64'h0); set_tb(64'h2_0000);
        chk("R10 reset code", rst_req, 2);
        rd(2'd1, v); chk("R10 status copy", v, 32'hE000_0000);
        @(negedge clk); chk("R10 one cycle", rst_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_ctrl;
        t_fit;
        t_pit;
        t_wdog;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule